// File: doc/BRIEF.md
# BCD Time-of-Day Register Bank

This block is the clock corner of a byte-addressed battery-backed memory map. The highest sixteen byte addresses of a 2^ADDR_W space form a register window. The upper eight bytes are a calendar clock: control, seconds, minutes, hours, weekday, date, month and year. The lower eight bytes hold flags, alarm settings, an interrupt byte and a watchdog byte. Addresses below the window are ordinary scratch bytes.

The clock keeps binary counters that step once per pulse on a one-pulse-per-second input, with the carry passing from seconds up to the year. On the bus, every counter appears as packed BCD. A write to a clock byte is decoded from BCD and checked against the legal range, and a value outside the range is dropped. With BASE_1968 set, the year counter holds years since 1900 and the bus shows the count minus 68, so a written 00 maps to 1968. Reads are synchronous: a read strobe loads the addressed byte into a register, where it stays until the next read.

A small watchdog state machine runs beside the clock. Its states are WD_OFF (disarmed), WD_COUNT (counting ticks) and WD_EXPIRED (expired). It moves through these transitions:
- A read of the watchdog byte with a nonzero value takes any state to WD_COUNT (load).
- A read of the watchdog byte with a zero value takes any state to WD_OFF (disarm).
- A tick in WD_COUNT with one count left moves to WD_EXPIRED (expire) and sets a sticky interrupt.
- A tick in WD_COUNT with more counts left stays in WD_COUNT (count down).
- Without a watchdog read, WD_OFF and WD_EXPIRED stay where they are (hold).

Top module: `rtc_tod_bank`

## Requirements
- R1: After reset, the clock bytes read as follows: 0x1FF8 = 0x00, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00. All stored bytes are 0x00, bus_rdata is 0x00 and wdog_irq is 0.
- R2: A read strobe updates bus_rdata at the next clock edge, using the state before that edge, and bus_rdata holds its value while no read is strobed. A scratch byte at an address below MEM_DEPTH returns the last byte written to it. Addresses from MEM_DEPTH up to the window read 0xFF and ignore writes.
- R3: Each tick advances the seconds count. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and produce a day carry.
- R4: A day carry steps the weekday (7 wraps to 1) and the date. The date wraps to 1, and the month advances, when the date is at or above the month length: 28 for February, 30 for April, June, September and November, and 31 for the other months. December wraps to January and advances the year. A shown year of 99 wraps to 00.
- R5: Writes to the clock bytes are BCD-decoded. A write is rejected, and the counter left unchanged, when either nibble is above 9 or the value is out of range. The ranges are: seconds (bits 6:0 only) 0..59, minutes 0..59, hours 0..23, date 1..31, month 1..12, year 0..99. The weekday takes bits 2:0 directly, in the range 1..7.
- R6: A seconds read returns bit 7 of the last byte written to 0x1FF9 in bit 7, with the BCD seconds in bits 6:0. A weekday read returns bits 7:3 of the last byte written to 0x1FFC, with the weekday count in bits 2:0. These stored bits are kept even when the count part of the write is rejected.
- R7: 0x1FF1 always reads 0x00, whatever was written to it. The bytes 0x1FF0, 0x1FF2..0x1FF7 and 0x1FF8 read back the last value written to them.
- R8: A tick in the same cycle as any write to 0x1FF9..0x1FFF is discarded for the clock counters.
- R9: A read of 0x1FF7 loads the watchdog with the stored byte N. If N is 0, the watchdog is disarmed. Otherwise every later tick decrements the count, and the tick that takes it from 1 to 0 sets wdog_irq. A reload before that point restarts the count. wdog_irq stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wdog_irq | output | 1 | Sticky watchdog expiry flag |

## Verification
The bench uses ADDR_W=13, MEM_DEPTH=64 and BASE_1968=1. With these values the window sits at 0x1FF0, and the scratch boundary at 64 is reachable from both sides with a few writes. In the 1968 mode the year wrap and the write offset are both exercised: a written 99 and the wrap to 00 go through the +68 mapping. Clock fields are preloaded by bus writes close to their limits, so the carries through the February, thirty-day and December month ends, and into the year, each take only a few ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        WD_OFF,
        WD_COUNT,
        WD_EXPIRED
    } wd_state_e;

    localparam logic [3:0] OFF_ZERO = 4'd1;
    localparam logic [3:0] OFF_WDOG = 4'd7;
    localparam logic [3:0] OFF_SEC  = 4'd9;
    localparam logic [3:0] OFF_MIN  = 4'd10;
    localparam logic [3:0] OFF_HOUR = 4'd11;
    localparam logic [3:0] OFF_WDAY = 4'd12;
    localparam logic [3:0] OFF_DATE = 4'd13;
    localparam logic [3:0] OFF_MON  = 4'd14;
    localparam logic [3:0] OFF_YEAR = 4'd15;

    // binary 0..99 to packed BCD
    function automatic logic [7:0] to_bcd(input logic [7:0] bin);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = bin / 8'd10;
        ones = bin % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // packed BCD to {valid, binary}
    function automatic logic [8:0] from_bcd(input logic [7:0] b);
        logic [7:0] v;
        v = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
        return {(b[7:4] <= 4'd9) && (b[3:0] <= 4'd9), v};
    endfunction

    // month index 0..11 to day count, no leap handling
    function automatic logic [4:0] days_in_month(input logic [3:0] m0);
        case (m0)
            4'd1:                      return 5'd28;
            4'd3, 4'd5, 4'd8, 4'd10:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
#(
    parameter int ADDR_W    = 13,
    parameter int MEM_DEPTH = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        mem_rd,
    output logic [15:0][7:0]  win_q
);
    localparam int IDX_W = $clog2(MEM_DEPTH);

    logic [7:0]       mem [MEM_DEPTH];
    logic             in_win;
    logic             in_mem;
    logic [IDX_W-1:0] idx;

    assign in_win = &addr[ADDR_W-1:4];
    assign in_mem = !in_win && (addr < ADDR_W'(MEM_DEPTH));
    assign idx    = addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en && in_mem) begin
            mem[idx] <= wdata;
        end
    end

    generate
        for (genvar g = 0; g < 16; g++) begin : g_win
            always_ff @(posedge clk) begin
                if (!rst_n)
                    win_q[g] <= 8'h00;
                else if (wr_en && in_win && (addr[3:0] == 4'(g)))
                    win_q[g] <= wdata;
            end
        end
    endgenerate

    assign mem_rd = in_mem ? mem[idx] : 8'hFF;

    // R2: a scratch write is visible at the written index on the next cycle
    assert_scratch_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_mem) |=> (mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/rtc_tod_counters.sv
module rtc_tod_counters
    import rtc_pkg::*;
#(
    parameter bit BASE_1968 = 1'b1
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [3:0] wr_off,
    input  logic [7:0] wr_val,
    output logic [5:0] sec_q,
    output logic [5:0] min_q,
    output logic [4:0] hour_q,
    output logic [2:0] wday_q,
    output logic [4:0] date_q,
    output logic [3:0] mon_q,
    output logic [7:0] year_q
);
    localparam logic [7:0] YEAR_MIN = BASE_1968 ? 8'd68 : 8'd0;
    localparam logic [7:0] YEAR_MAX = YEAR_MIN + 8'd99;

    logic [7:0] year_cnt;
    logic [8:0] dec_full;
    logic [8:0] dec_sec;
    logic       c_sec, c_min, c_hour, c_date, c_mon;

    assign dec_full = from_bcd(wr_val);
    assign dec_sec  = from_bcd({1'b0, wr_val[6:0]});

    always_comb begin
        c_sec  = (sec_q == 6'd59);
        c_min  = c_sec && (min_q == 6'd59);
        c_hour = c_min && (hour_q == 5'd23);
        c_date = c_hour && (date_q >= days_in_month(mon_q));
        c_mon  = c_date && (mon_q == 4'd11);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q    <= '0;
            min_q    <= '0;
            hour_q   <= '0;
            wday_q   <= 3'd1;
            date_q   <= 5'd1;
            mon_q    <= '0;
            year_cnt <= YEAR_MIN;
        end else if (wr_en) begin
            case (wr_off)
                OFF_SEC:  if (dec_sec[8] && dec_sec[7:0] < 8'd60)   sec_q  <= dec_sec[5:0];
                OFF_MIN:  if (dec_full[8] && dec_full[7:0] < 8'd60) min_q  <= dec_full[5:0];
                OFF_HOUR: if (dec_full[8] && dec_full[7:0] < 8'd24) hour_q <= dec_full[4:0];
                OFF_WDAY: if (wr_val[2:0] != 3'd0)                  wday_q <= wr_val[2:0];
                OFF_DATE: if (dec_full[8] && dec_full[7:0] >= 8'd1 && dec_full[7:0] <= 8'd31)
                              date_q <= dec_full[4:0];
                OFF_MON:  if (dec_full[8] && dec_full[7:0] >= 8'd1 && dec_full[7:0] <= 8'd12)
                              mon_q <= dec_full[3:0] - 4'd1;
                OFF_YEAR: if (dec_full[8] && dec_full[7:0] <= 8'd99)
                              year_cnt <= dec_full[7:0] + YEAR_MIN;
                default: ;
            endcase
        end else if (tick) begin
            sec_q <= c_sec ? 6'd0 : sec_q + 6'd1;
            if (c_sec)  min_q  <= (min_q == 6'd59) ? 6'd0 : min_q + 6'd1;
            if (c_min)  hour_q <= (hour_q == 5'd23) ? 5'd0 : hour_q + 5'd1;
            if (c_hour) begin
                wday_q <= (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
                date_q <= c_date ? 5'd1 : date_q + 5'd1;
            end
            if (c_date) mon_q <= c_mon ? 4'd0 : mon_q + 4'd1;
            if (c_mon)  year_cnt <= (year_cnt == YEAR_MAX) ? YEAR_MIN : year_cnt + 8'd1;
        end
    end

    assign year_q = year_cnt - YEAR_MIN;

    // R3: fields stay inside their ranges
    assert_time_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q < 6'd60) && (min_q < 6'd60) && (hour_q < 5'd24));
    // R4: calendar fields stay inside their ranges
    assert_cal_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wday_q != 3'd0) && (date_q != 5'd0) && (mon_q < 4'd12) && (year_q < 8'd100));
    // R3: a plain tick below 59 steps seconds by one
    assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && sec_q != 6'd59) |=> (sec_q == $past(sec_q) + 6'd1));
    // R8: a tick during a clock write that is not to seconds leaves seconds alone
    assert_tick_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wr_en && wr_off != OFF_SEC) |=> $stable(sec_q));

endmodule

// File: rtl/rtc_watchdog.sv
module rtc_watchdog
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reload,
    input  logic [7:0] reload_val,
    output logic       irq
);
    wd_state_e  state, state_nx;
    logic [7:0] cnt, cnt_nx;
    logic       irq_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_OFF;
            cnt   <= '0;
            irq   <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            irq   <= irq_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (reload) begin
            if (reload_val == 8'd0) begin
                state_nx = WD_OFF;
                cnt_nx   = '0;
            end else begin
                state_nx = WD_COUNT;
                cnt_nx   = reload_val;
            end
        end else begin
            unique case (state)
                WD_OFF:     ;
                WD_COUNT:   if (tick) begin
                                if (cnt == 8'd1) begin
                                    state_nx = WD_EXPIRED;
                                    cnt_nx   = '0;
                                end else begin
                                    cnt_nx = cnt - 8'd1;
                                end
                            end
                WD_EXPIRED: ;
                default:    state_nx = WD_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        irq_nx = irq || (state == WD_COUNT && state_nx == WD_EXPIRED);
    end

    // R9: the expiry flag never clears outside reset
    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq);
    // R9: last count tick without reload raises the flag
    assert_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_COUNT && cnt == 8'd1 && tick && !reload) |=> irq);
    // R9: a disarmed watchdog stays disarmed until reloaded
    assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_OFF && !reload) |=> (state == WD_OFF));

endmodule

// File: rtl/rtc_tod_bank.sv
module rtc_tod_bank
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int MEM_DEPTH = 64,
    parameter bit BASE_1968 = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              wdog_irq
);
    logic             in_win;
    logic [3:0]       off;
    logic             time_wr;
    logic [7:0]       mem_rd;
    logic [15:0][7:0] win_q;
    logic [5:0]       sec_q, min_q;
    logic [4:0]       hour_q, date_q;
    logic [2:0]       wday_q;
    logic [3:0]       mon_q;
    logic [7:0]       year_q;
    logic [7:0]       sec_bcd, min_bcd, hour_bcd, date_bcd, mon_bcd, year_bcd;
    logic [7:0]       rd_mux;

    assign in_win  = &bus_addr[ADDR_W-1:4];
    assign off     = bus_addr[3:0];
    assign time_wr = bus_wr && in_win && (off >= OFF_SEC);

    rtc_byte_store #(.ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .mem_rd (mem_rd),
        .win_q  (win_q)
    );

    rtc_tod_counters #(.BASE_1968(BASE_1968)) u_tod (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .wr_en  (time_wr),
        .wr_off (off),
        .wr_val (bus_wdata),
        .sec_q  (sec_q),
        .min_q  (min_q),
        .hour_q (hour_q),
        .wday_q (wday_q),
        .date_q (date_q),
        .mon_q  (mon_q),
        .year_q (year_q)
    );

    rtc_watchdog u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_1hz),
        .reload     (bus_rd && in_win && off == OFF_WDOG),
        .reload_val (win_q[OFF_WDOG]),
        .irq        (wdog_irq)
    );

    assign sec_bcd  = to_bcd({2'b00, sec_q});
    assign min_bcd  = to_bcd({2'b00, min_q});
    assign hour_bcd = to_bcd({3'b000, hour_q});
    assign date_bcd = to_bcd({3'b000, date_q});
    assign mon_bcd  = to_bcd({4'd0, mon_q} + 8'd1);
    assign year_bcd = to_bcd(year_q);

    always_comb begin
        if (!in_win) begin
            rd_mux = mem_rd;
        end else begin
            case (off)
                OFF_ZERO: rd_mux = 8'h00;
                OFF_SEC:  rd_mux = {win_q[OFF_SEC][7], sec_bcd[6:0]};
                OFF_MIN:  rd_mux = min_bcd;
                OFF_HOUR: rd_mux = hour_bcd;
                OFF_WDAY: rd_mux = {win_q[OFF_WDAY][7:3], wday_q};
                OFF_DATE: rd_mux = date_bcd;
                OFF_MON:  rd_mux = mon_bcd;
                OFF_YEAR: rd_mux = year_bcd;
                default:  rd_mux = win_q[off];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 8'h00;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    // R7: the unused window byte always reads zero
    assert_zero_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_win && off == OFF_ZERO) |=> (bus_rdata == 8'h00));
    // R2: read data holds between read strobes
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R2: reads above scratch depth but below the window return all ones
    assert_gap_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_win && bus_addr >= ADDR_W'(MEM_DEPTH)) |=> (bus_rdata == 8'hFF));

endmodule

// File: tb/rtc_tod_bank_tb.sv
module rtc_tod_bank_tb;
    localparam int ADDR_W    = 13;
    localparam int MEM_DEPTH = 64;
    localparam int WIN       = (1 << ADDR_W) - 16;
    localparam int CLK_HALF  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_1hz = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              wdog_irq;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // reference model state (shown values)
    int m_sec, m_min, m_hr, m_wday, m_date, m_mon, m_yr;
    int m_win [16];
    int m_mem [MEM_DEPTH];
    int wd_st, wd_cnt;
    bit m_irq;
    int exp_rd;

    rtc_tod_bank #(.ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH), .BASE_1968(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_irq(wdog_irq)
    );

    always #CLK_HALF clk = ~clk;

    function automatic int bcd(int v);
        return (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int mlen(int m);
        if (m == 2) return 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int model_read(int a);
        int o;
        if (a < WIN) return (a < MEM_DEPTH) ? m_mem[a] : 255;
        o = a - WIN;
        case (o)
            1:  return 0;
            9:  return (m_win[9] & 128) | bcd(m_sec);
            10: return bcd(m_min);
            11: return bcd(m_hr);
            12: return (m_win[12] & 248) | m_wday;
            13: return bcd(m_date);
            14: return bcd(m_mon);
            15: return bcd(m_yr);
            default: return m_win[o];
        endcase
    endfunction

    task automatic model_write(int a, int v);
        int o, hi, lo, d;
        bit ok;
        if (a < WIN) begin
            if (a < MEM_DEPTH) m_mem[a] = v;
            return;
        end
        o = a - WIN;
        m_win[o] = v;
        hi = (o == 9) ? ((v & 127) >> 4) : (v >> 4);
        lo = v & 15;
        ok = (hi <= 9) && (lo <= 9);
        d  = hi * 10 + lo;
        case (o)
            9:  if (ok && d < 60) m_sec = d;
            10: if (ok && d < 60) m_min = d;
            11: if (ok && d < 24) m_hr = d;
            12: if ((v & 7) != 0) m_wday = v & 7;
            13: if (ok && d >= 1 && d <= 31) m_date = d;
            14: if (ok && d >= 1 && d <= 12) m_mon = d;
            15: if (ok && d <= 99) m_yr = d;
            default: ;
        endcase
    endtask

    task automatic model_tick();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        m_wday = (m_wday == 7) ? 1 : m_wday + 1;
        if (m_date >= mlen(m_mon)) begin
            m_date = 1;
            if (m_mon == 12) begin
                m_mon = 1;
                m_yr = (m_yr == 99) ? 0 : m_yr + 1;
            end else m_mon++;
        end else m_date++;
    endtask

    always @(posedge clk) begin
        int a;
        bit tw;
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_wday = 1; m_date = 1; m_mon = 1; m_yr = 0;
            for (int i = 0; i < 16; i++) m_win[i] = 0;
            for (int i = 0; i < MEM_DEPTH; i++) m_mem[i] = 0;
            wd_st = 0; wd_cnt = 0; m_irq = 0; exp_rd = 0;
        end else begin
            a  = int'(bus_addr);
            tw = bus_wr && (a >= WIN + 9);
            if (bus_rd) exp_rd = model_read(a);
            if (bus_rd && a == WIN + 7) begin
                if (m_win[7] == 0) begin wd_st = 0; wd_cnt = 0; end
                else begin wd_st = 1; wd_cnt = m_win[7]; end
            end else if (wd_st == 1 && tick_1hz) begin
                if (wd_cnt == 1) begin wd_st = 2; wd_cnt = 0; m_irq = 1; end
                else wd_cnt--;
            end
            if (bus_wr) model_write(a, int'(bus_wdata));
            if (tick_1hz && !tw) model_tick();
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (int'(bus_rdata) != exp_rd) begin
                n_bad++;
                $display("FAIL %s bus_rdata actual %02h expected %02h", cur_req, bus_rdata, exp_rd[7:0]);
            end
            n_vec++;
            if (wdog_irq != m_irq) begin
                n_bad++;
                $display("FAIL %s wdog_irq actual %0d expected %0d", cur_req, wdog_irq, m_irq);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog run timeout actual %0d expected <100000", cycles);
            summary();
        end
    end

    task automatic wr(int a, int d, bit tk = 1'b0);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = 8'(d); tick_1hz = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic rd(int a);
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            tick_1hz = 1'b1;
            @(negedge clk);
            tick_1hz = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic rd_clock();
        for (int o = 8; o < 16; o++) rd(WIN + o);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        rd_clock();

        cur_req = "R2";
        wr(0, 8'h3C); wr(5, 8'hA5); wr(63, 8'h7E);
        rd(0); rd(5); rd(63);
        wr(64, 8'h11); rd(64); rd(4000); rd(WIN - 1);
        repeat (2) @(negedge clk);

        cur_req = "R7";
        for (int o = 0; o < 9; o++) wr(WIN + o, 8'h40 + o * 7);
        wr(WIN + 1, 8'hAA);
        for (int o = 0; o < 9; o++) rd(WIN + o);

        cur_req = "R6";
        wr(WIN + 9, 8'hD8); wr(WIN + 12, 8'hFF); rd(WIN + 9); rd(WIN + 12);
        wr(WIN + 9, 8'hE5); wr(WIN + 12, 8'hA8); rd(WIN + 9); rd(WIN + 12);

        cur_req = "R3";
        wr(WIN + 9, 8'h58); wr(WIN + 10, 8'h59); wr(WIN + 11, 8'h23);
        wr(WIN + 12, 8'h07);
        cur_req = "R4";
        wr(WIN + 13, 8'h28); wr(WIN + 14, 8'h02); wr(WIN + 15, 8'h99);
        tick(2); rd_clock();
        wr(WIN + 14, 8'h12); wr(WIN + 13, 8'h31);
        wr(WIN + 11, 8'h23); wr(WIN + 10, 8'h59); wr(WIN + 9, 8'h59);
        tick(1); rd_clock();
        wr(WIN + 14, 8'h04); wr(WIN + 13, 8'h31);
        wr(WIN + 11, 8'h23); wr(WIN + 10, 8'h59); wr(WIN + 9, 8'h59);
        tick(1); rd_clock();
        cur_req = "R3";
        tick(5); rd_clock();

        cur_req = "R5";
        wr(WIN + 9, 8'h60); wr(WIN + 9, 8'h5A); wr(WIN + 10, 8'h60);
        wr(WIN + 11, 8'h24); wr(WIN + 12, 8'hF8); wr(WIN + 13, 8'h00);
        wr(WIN + 13, 8'h32); wr(WIN + 14, 8'h00); wr(WIN + 14, 8'h13);
        wr(WIN + 15, 8'hA0); wr(WIN + 15, 8'h1F);
        rd_clock();
        wr(WIN + 9, 8'h42); wr(WIN + 10, 8'h17); wr(WIN + 11, 8'h09);
        wr(WIN + 15, 8'h00); wr(WIN + 14, 8'h09);
        rd_clock();

        cur_req = "R8";
        wr(WIN + 10, 8'h33, 1'b1); wr(WIN + 15, 8'h45, 1'b1);
        rd_clock();

        cur_req = "R9";
        wr(WIN + 7, 8'h03); rd(WIN + 7);
        tick(2); rd(WIN + 7);
        tick(2); rd(WIN + 9);
        tick(1); rd(WIN + 9);
        tick(2);
        wr(WIN + 7, 8'h00); rd(WIN + 7);
        tick(3);
        repeat (3) @(negedge clk);

        summary();
    end

endmodule